// File: doc/BRIEF.md
# Incremental Plotter Adapter

This block sits on the device side of a minicomputer I/O channel and drives a pen-and-drum incremental plotter. Each I/O command carries an area code. The block acts only on commands whose area code equals its own. It accepts three kinds of command: write-data, plain sense, and sense-with-reset.

An accepted data word becomes one set of step pulses. There is at most one pulse per motion line: drum forward or reverse, carriage forward or reverse, pen up or pen down. After the pulses end, a settle interval runs. When the interval ends, the block raises an interrupt request on priority level 3. The request stays raised until the processor issues a sense-with-reset.

A ready input, wired to an external switch, gates all write acceptance. A sense command returns a status word that reports four things: the inverse of that input, busy, a sticky refused-write flag and the pending interrupt. The motor drivers and the interrupt controller are outside this block. The block only produces pulse lines and a request line.

Top module: `plot_step_adapter`

## Requirements
- R1: While `rst` is high and after it falls, `step_o`, `irq_l3`, `sense_valid` and `sense_word` are all zero.
- R2: A command whose `cmd_area` differs from `PLOT_AREA` has no effect. No pulse, no sense response and no status change follows.
- R3: The step lines in `step_o` are bit 0 drum forward, bit 1 drum reverse, bit 2 carriage forward, bit 3 carriage reverse, bit 4 pen up and bit 5 pen down. An accepted write drives every line whose data bit is set. Each driven line goes high for exactly `PULSE_CYC` cycles, starting the cycle after the command. All other lines stay low.
- R4: A data word is valid when bits 5:0 are not all zero and no opposing pair (0/1, 2/3, 4/5) is fully set. Bits above 5 are ignored.
- R5: `irq_l3` rises `SETTLE_CYC` cycles after the pulses end. If bit 4 or bit 5 was set, it rises `PEN_SETTLE_CYC` cycles after instead. The device counts as busy from acceptance until that rise.
- R6: A write is refused when the device is busy, when `dev_ready` is low, or when the word is invalid. A refused write produces no pulse and sets the sticky refused flag.
- R7: A sense command makes `sense_valid` high for the following cycle. The returned `sense_word` holds: bit 0 = not ready (inverse of `dev_ready` at the command), bit 1 = busy, bit 2 = refused flag, bit 15 = interrupt pending. All other bits are zero.
- R8: Sense-with-reset is a sense with `cmd_reset` high. It returns the status as it was before clearing. From the next cycle, `irq_l3` and the refused flag are zero.
- R9: `irq_l3` stays high across plain sense commands and across later accepted writes, until a sense-with-reset clears it.
- R10: Function encoding on `cmd_func` is 2'b01 write-data and 2'b11 sense. The other two codes do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_area | input | AREA_W | Area code of the command |
| cmd_func | input | 2 | Function: 01 write, 11 sense |
| cmd_reset | input | 1 | On a sense: clear interrupt and refused flag |
| cmd_data | input | DATA_W | Movement word for a write |
| dev_ready | input | 1 | Ready switch |
| step_o | output | 6 | Step pulse lines |
| irq_l3 | output | 1 | Level-3 interrupt request |
| sense_valid | output | 1 | Status word valid |
| sense_word | output | DATA_W | Status word |

## Verification
The hardest situation to reach is a command that arrives while a movement is still pulsing or settling. This covers a second write, a sense that must report busy, and a write issued while an earlier interrupt is still pending. Directed sequences issue these commands back to back on the cycles right after an accepted write. Random words, some built valid field by field and some raw, cover the pen-dependent settle length. Those runs also cover refusal of conflicting words and of writes with the ready switch off.

// File: rtl/plot_pkg.sv
package plot_pkg;
  localparam int STEP_N     = 6;
  localparam int B_DRUM_FWD = 0;
  localparam int B_DRUM_REV = 1;
  localparam int B_CARR_FWD = 2;
  localparam int B_CARR_REV = 3;
  localparam int B_PEN_UP   = 4;
  localparam int B_PEN_DOWN = 5;
  localparam int PAIR_N     = STEP_N / 2;

  localparam int SB_NOT_READY = 0;
  localparam int SB_BUSY      = 1;
  localparam int SB_REFUSED   = 2;

  typedef enum logic [1:0] {
    FN_NONE  = 2'b00,
    FN_WRITE = 2'b01,
    FN_RSVD  = 2'b10,
    FN_SENSE = 2'b11
  } plot_fn_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_PULSE  = 2'd1,
    SQ_SETTLE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/plot_cmd_decode.sv
module plot_cmd_decode
  import plot_pkg::*;
#(
  parameter int AREA_W = 5,
  parameter int DATA_W = 16,
  parameter logic [AREA_W-1:0] PLOT_AREA = 5'd6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid_i,
  input  logic [AREA_W-1:0] cmd_area_i,
  input  logic [1:0]        cmd_func_i,
  input  logic              cmd_reset_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              dev_ready_i,
  input  logic              busy_i,
  output logic              wr_accept_o,
  output logic              wr_refuse_o,
  output logic              sense_req_o,
  output logic              sense_clear_o,
  output logic [STEP_N-1:0] move_bits_o
);
  logic [PAIR_N-1:0] conflict;
  logic              hit, is_wr, word_ok;
  plot_fn_e          fn;
  logic              unused_hi;

  assign move_bits_o = cmd_data_i[STEP_N-1:0];
  assign unused_hi   = ^cmd_data_i[DATA_W-1:STEP_N];

  for (genvar g = 0; g < PAIR_N; g++) begin : g_pair
    assign conflict[g] = move_bits_o[2*g] & move_bits_o[2*g+1];
  end

  always_comb begin
    fn            = plot_fn_e'(cmd_func_i);
    hit           = cmd_valid_i && (cmd_area_i == PLOT_AREA);
    is_wr         = hit && (fn == FN_WRITE);
    word_ok       = (|move_bits_o) && !(|conflict);
    wr_accept_o   = is_wr && dev_ready_i && !busy_i && word_ok;
    wr_refuse_o   = is_wr && !wr_accept_o;
    sense_req_o   = hit && (fn == FN_SENSE);
    sense_clear_o = sense_req_o && cmd_reset_i;
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_accept_o, wr_refuse_o, sense_req_o})); // R2
  AST_READY_GATE: assert property (@(posedge clk) disable iff (rst)
    wr_accept_o |-> (dev_ready_i && !busy_i)); // R6
endmodule

// File: rtl/plot_step_seq.sv
module plot_step_seq
  import plot_pkg::*;
#(
  parameter int PULSE_CYC      = 4,
  parameter int SETTLE_CYC     = 6,
  parameter int PEN_SETTLE_CYC = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [STEP_N-1:0] bits_i,
  output logic [STEP_N-1:0] step_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int MAX_A  = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int MAX_C  = (MAX_A > PEN_SETTLE_CYC) ? MAX_A : PEN_SETTLE_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] PLAIN_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] PEN_LAST   = CNT_W'(PEN_SETTLE_CYC - 1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [STEP_N-1:0] step_q;
  logic              pen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      step_q  <= '0;
      pen_q   <= 1'b0;
    end else begin
      case (state_q)
        SQ_IDLE: if (start_i) begin
          state_q <= SQ_PULSE;
          step_q  <= bits_i;
          cnt_q   <= PULSE_LAST;
          pen_q   <= bits_i[B_PEN_UP] | bits_i[B_PEN_DOWN];
        end
        SQ_PULSE: if (cnt_q == '0) begin
          state_q <= SQ_SETTLE;
          step_q  <= '0;
          cnt_q   <= pen_q ? PEN_LAST : PLAIN_LAST;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
        SQ_SETTLE: if (cnt_q == '0) begin
          state_q <= SQ_IDLE;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign step_o = step_q;
  assign busy_o = (state_q != SQ_IDLE);
  assign done_o = (state_q == SQ_SETTLE) && (cnt_q == '0);

  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    start_i |-> (state_q == SQ_IDLE)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state_q != SQ_PULSE) |-> (step_q == '0)); // R3
  AST_PULSE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_PULSE && $past(state_q == SQ_PULSE)) |-> $stable(step_q)); // R3
endmodule

// File: rtl/plot_status.sv
module plot_status
  import plot_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_refuse_i,
  input  logic              sense_req_i,
  input  logic              sense_clear_i,
  input  logic              done_i,
  input  logic              busy_i,
  input  logic              dev_ready_i,
  output logic              irq_o,
  output logic              sense_valid_o,
  output logic [DATA_W-1:0] sense_word_o
);
  localparam int SB_IRQ = DATA_W - 1;

  logic              irq_q, refused_q, valid_q;
  logic [DATA_W-1:0] word_q, word_d;

  always_comb begin
    word_d               = '0;
    word_d[SB_NOT_READY] = ~dev_ready_i;
    word_d[SB_BUSY]      = busy_i;
    word_d[SB_REFUSED]   = refused_q;
    word_d[SB_IRQ]       = irq_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q     <= 1'b0;
      refused_q <= 1'b0;
      valid_q   <= 1'b0;
      word_q    <= '0;
    end else begin
      valid_q <= sense_req_i;
      if (sense_req_i) word_q <= word_d;
      if (done_i) irq_q <= 1'b1;
      else if (sense_clear_i) irq_q <= 1'b0;
      if (wr_refuse_i) refused_q <= 1'b1;
      else if (sense_clear_i) refused_q <= 1'b0;
    end
  end

  assign irq_o         = irq_q;
  assign sense_valid_o = valid_q;
  assign sense_word_o  = word_q;

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !sense_clear_i) |=> irq_q); // R9
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (sense_clear_i && !done_i) |=> !irq_q); // R8
  AST_SENSE_ECHO: assert property (@(posedge clk) disable iff (rst)
    sense_req_i |=> sense_valid_o); // R7
  AST_REFUSED_STICKY: assert property (@(posedge clk) disable iff (rst)
    wr_refuse_i |=> refused_q); // R6
endmodule

// File: rtl/plot_step_adapter.sv
module plot_step_adapter
  import plot_pkg::*;
#(
  parameter int AREA_W = 5,
  parameter int DATA_W = 16,
  parameter logic [AREA_W-1:0] PLOT_AREA = 5'd6,
  parameter int PULSE_CYC      = 4,
  parameter int SETTLE_CYC     = 6,
  parameter int PEN_SETTLE_CYC = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [AREA_W-1:0] cmd_area,
  input  logic [1:0]        cmd_func,
  input  logic              cmd_reset,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              dev_ready,
  output logic [5:0]        step_o,
  output logic              irq_l3,
  output logic              sense_valid,
  output logic [DATA_W-1:0] sense_word
);
  logic              wr_accept, wr_refuse, sense_req, sense_clear;
  logic              busy, done;
  logic [STEP_N-1:0] move_bits;

  plot_cmd_decode #(.AREA_W(AREA_W), .DATA_W(DATA_W), .PLOT_AREA(PLOT_AREA)) u_dec (
    .clk(clk), .rst(rst),
    .cmd_valid_i(cmd_valid), .cmd_area_i(cmd_area), .cmd_func_i(cmd_func),
    .cmd_reset_i(cmd_reset), .cmd_data_i(cmd_data), .dev_ready_i(dev_ready),
    .busy_i(busy), .wr_accept_o(wr_accept), .wr_refuse_o(wr_refuse),
    .sense_req_o(sense_req), .sense_clear_o(sense_clear), .move_bits_o(move_bits)
  );

  plot_step_seq #(.PULSE_CYC(PULSE_CYC), .SETTLE_CYC(SETTLE_CYC),
                  .PEN_SETTLE_CYC(PEN_SETTLE_CYC)) u_seq (
    .clk(clk), .rst(rst), .start_i(wr_accept), .bits_i(move_bits),
    .step_o(step_o), .busy_o(busy), .done_o(done)
  );

  plot_status #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst(rst), .wr_refuse_i(wr_refuse), .sense_req_i(sense_req),
    .sense_clear_i(sense_clear), .done_i(done), .busy_i(busy),
    .dev_ready_i(dev_ready), .irq_o(irq_l3), .sense_valid_o(sense_valid),
    .sense_word_o(sense_word)
  );
endmodule

// File: tb/plot_step_adapter_tb_top.sv
module plot_step_adapter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 16;
  localparam logic [AW-1:0] AREA = 5'd6;
  localparam int P  = 4;
  localparam int S  = 6;
  localparam int PS = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [AW-1:0] cmd_area = '0;
  logic [1:0]    cmd_func = 2'b00;
  logic          cmd_reset = 1'b0;
  logic [DW-1:0] cmd_data = '0;
  logic          dev_ready = 1'b1;
  logic [5:0]    step_o;
  logic          irq_l3, sense_valid;
  logic [DW-1:0] sense_word;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  plot_step_adapter #(.AREA_W(AW), .DATA_W(DW), .PLOT_AREA(AREA), .PULSE_CYC(P),
                      .SETTLE_CYC(S), .PEN_SETTLE_CYC(PS)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_area(cmd_area),
    .cmd_func(cmd_func), .cmd_reset(cmd_reset), .cmd_data(cmd_data),
    .dev_ready(dev_ready), .step_o(step_o), .irq_l3(irq_l3),
    .sense_valid(sense_valid), .sense_word(sense_word)
  );

  function automatic logic word_ok(input logic [5:0] f);
    return (f != 6'd0) && !(f[0] && f[1]) && !(f[2] && f[3]) && !(f[4] && f[5]);
  endfunction

  function automatic logic [DW-1:0] exp_word(input logic nr, input logic bsy,
                                            input logic rf, input logic irq);
    logic [DW-1:0] w;
    w = '0; w[0] = nr; w[1] = bsy; w[2] = rf; w[DW-1] = irq;
    return w;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [AW-1:0] a, input logic [1:0] fn,
                       input logic rb, input logic [DW-1:0] d);
    cmd_area = a; cmd_func = fn; cmd_reset = rb; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_func = 2'b00; cmd_reset = 1'b0;
  endtask

  task automatic sense(input logic rb, output logic [DW-1:0] w);
    issue(AREA, 2'b11, rb, '0);
    chk("R7", "sense_valid", 32'(sense_valid), 32'd1);
    w = sense_word;
  endtask

  task automatic clear_all();
    logic [DW-1:0] w;
    sense(1'b1, w);
  endtask

  task automatic do_move(input string req, input logic [DW-1:0] d);
    logic [5:0] e;
    int st;
    e  = d[5:0];
    st = (e[4] || e[5]) ? PS : S;
    issue(AREA, 2'b01, 1'b0, d);
    for (int k = 0; k < P; k++) begin
      chk("R3", "step during pulse", 32'(step_o), 32'(e));
      @(negedge clk);
    end
    chk("R3", "step after pulse", 32'(step_o), 32'd0);
    for (int j = 1; j < st; j++) begin
      @(negedge clk);
      chk("R5", "irq early", 32'(irq_l3), 32'd0);
    end
    @(negedge clk);
    chk(req, "irq at settle end", 32'(irq_l3), 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] w;
    logic [DW-1:0] d;
    bit seen_b;
    void'($urandom(32'h5EED1627));
    repeat (4) @(negedge clk);
    chk("R1", "step in reset", 32'(step_o), 32'd0);
    chk("R1", "irq in reset", 32'(irq_l3), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "step after reset", 32'(step_o), 32'd0);
    chk("R1", "irq after reset", 32'(irq_l3), 32'd0);
    chk("R1", "sense_valid after reset", 32'(sense_valid), 32'd0);
    chk("R1", "sense_word after reset", 32'(sense_word), 32'd0);

    // R2: foreign area
    issue(AREA ^ 5'd1, 2'b01, 1'b0, 16'h0001);
    repeat (3) begin
      chk("R2", "step on foreign write", 32'(step_o), 32'd0);
      @(negedge clk);
    end
    issue(AREA ^ 5'd3, 2'b11, 1'b0, '0);
    chk("R2", "sense_valid on foreign sense", 32'(sense_valid), 32'd0);
    sense(1'b0, w);
    chk("R2", "status untouched", 32'(w), 32'(exp_word(0, 0, 0, 0)));

    // R10: unused function codes
    issue(AREA, 2'b10, 1'b0, 16'h0004);
    chk("R10", "step on code 10", 32'(step_o), 32'd0);
    chk("R10", "sense_valid on code 10", 32'(sense_valid), 32'd0);
    issue(AREA, 2'b00, 1'b0, 16'h0004);
    chk("R10", "step on code 00", 32'(step_o), 32'd0);

    // R6/R7: not ready
    dev_ready = 1'b0;
    issue(AREA, 2'b01, 1'b0, 16'h0001);
    chk("R6", "step while not ready", 32'(step_o), 32'd0);
    sense(1'b0, w);
    chk("R7", "not ready word", 32'(w), 32'(exp_word(1, 0, 1, 0)));
    dev_ready = 1'b1;
    sense(1'b1, w);
    chk("R8", "reset sense returns prior", 32'(w), 32'(exp_word(0, 0, 1, 0)));
    sense(1'b0, w);
    chk("R8", "refused cleared", 32'(w), 32'(exp_word(0, 0, 0, 0)));

    // R3/R5 directed: carriage only, then pen
    do_move("R5", 16'h0004);
    sense(1'b0, w);
    chk("R9", "irq shown in sense", 32'(w), 32'(exp_word(0, 0, 0, 1)));
    chk("R9", "irq held after plain sense", 32'(irq_l3), 32'd1);
    sense(1'b1, w);
    chk("R8", "reset sense shows irq", 32'(w), 32'(exp_word(0, 0, 0, 1)));
    chk("R8", "irq cleared", 32'(irq_l3), 32'd0);
    do_move("R5", 16'hFF21);

    // R6: write while busy; R7 busy bit; R9 irq across new write
    clear_all();
    issue(AREA, 2'b01, 1'b0, 16'h0001);
    chk("R3", "first pattern", 32'(step_o), 32'd1);
    issue(AREA, 2'b01, 1'b0, 16'h0004);
    chk("R6", "busy write ignored", 32'(step_o), 32'd1);
    sense(1'b0, w);
    chk("R7", "busy word", 32'(w), 32'(exp_word(0, 1, 1, 0)));
    seen_b = 0;
    for (int i = 0; i < 40 && !irq_l3; i++) begin
      if (step_o == 6'd4) seen_b = 1;
      @(negedge clk);
    end
    chk("R6", "second pattern never seen", 32'(seen_b), 32'd0);
    chk("R5", "irq after busy run", 32'(irq_l3), 32'd1);
    issue(AREA, 2'b01, 1'b0, 16'h0008);
    for (int i = 0; i < P + S + 2; i++) begin
      chk("R9", "irq held during new move", 32'(irq_l3), 32'd1);
      @(negedge clk);
    end
    sense(1'b1, w);
    chk("R8", "reset sense prior state", 32'(w), 32'(exp_word(0, 0, 1, 1)));
    sense(1'b0, w);
    chk("R8", "all clear", 32'(w), 32'(exp_word(0, 0, 0, 0)));

    // R4: conflicting pairs, zero word
    issue(AREA, 2'b01, 1'b0, 16'h0003);
    chk("R4", "drum conflict ignored", 32'(step_o), 32'd0);
    issue(AREA, 2'b01, 1'b0, 16'hFFC0);
    chk("R4", "empty field word ignored", 32'(step_o), 32'd0);
    sense(1'b1, w);
    chk("R4", "refused flag", 32'(w), 32'(exp_word(0, 0, 1, 0)));

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic rdy;
      d = 16'($urandom);
      if (i % 2 == 0) begin
        int a, b, c;
        a = int'($urandom % 3); b = int'($urandom % 3); c = int'($urandom % 3);
        d[5:0] = {c == 2, c == 1, b == 2, b == 1, a == 2, a == 1};
      end
      rdy = (i % 7 != 3);
      dev_ready = rdy;
      if (rdy && word_ok(d[5:0])) begin
        do_move("R3", d);
      end else begin
        issue(AREA, 2'b01, 1'b0, d);
        chk("R6", "refused write no step", 32'(step_o), 32'd0);
        @(negedge clk);
        chk("R6", "refused write no step 2", 32'(step_o), 32'd0);
        sense(1'b0, w);
        chk("R6", "refused status", 32'(w), 32'(exp_word(!rdy, 0, 1, 0)));
      end
      dev_ready = 1'b1;
      clear_all();
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule